// File: doc/BRIEF.md
# Serial ADC Converter-Side Frame and Power-Mode Controller

This block is the digital control logic that sits on the converter side of a three-wire serial analog-to-digital converter. It runs from a fast system clock and treats the active-low chip-select and the serial clock as asynchronous inputs. Each input passes through a synchroniser, and edges are detected on the synchronised copies. A falling chip-select opens a frame. The block then counts serial-clock edges, shifts a 16-bit output word onto the serial data pin and drives that pin's enable, which stands for its high-impedance control. It also raises hold and track pulses for the sampler. The 12-bit parallel sample word is supplied from outside and is latched when the frame opens.

How many falling serial-clock edges had occurred when chip-select is released decides the power mode. The block moves among three modes: shutdown, waking and normal. It flags every completed word as valid or as a dummy conversion. The reset mode is chosen by a parameter, so both start-up cases can be reproduced.

Top module: `sadc_pwr_ctrl`

## Requirements
- R1: A synchronised falling edge of `cs_n` asserts `hold` and `sdo_en`, gives a one-cycle `hold_pulse`, and latches `sample_word` for the frame.
- R2: The output word is 16 bit-times long. Bit 0 is on `sdo` from the chip-select fall, and bit k appears after the k-th falling `sclk` edge. Bits 0 to 2 are zero, bits 3 to 14 carry the sample most significant bit first, and bit 15 is zero.
- R3: `hold` drops on the 13th rising `sclk` edge of the frame, or at an earlier release of chip-select. Each frame gives exactly one one-cycle `track_pulse`.
- R4: `sdo_en` drops on the 16th falling edge or at release of chip-select, whichever comes first. Further `sclk` edges in the frame change neither `sdo_en` nor the frame result.
- R5: In normal mode (`pwr_state` = 2'b10), releasing chip-select after fewer than 2 falling edges leaves the mode unchanged.
- R6: In normal mode, a release after 2 to 9 falling edges ends the frame and enters shutdown (`pwr_state` = 2'b00).
- R7: In normal mode, a release after 10 to 15 falling edges truncates the word, gives no `frame_done`, and keeps normal mode.
- R8: A chip-select fall in shutdown enters the waking mode (`pwr_state` = 2'b01). The 10th falling edge then moves the block to normal mode, and a release before that edge returns it to shutdown. The encoding 2'b11 never appears.
- R9: `frame_done` pulses for one cycle on the 16th falling edge. `frame_valid` pulses with it unless the frame is a dummy. A frame is a dummy if it is the first frame started after reset or if it was started outside normal mode.
- R10: After reset, `pwr_state` is 2'b10 when `RESET_NORMAL` is 1 and 2'b00 when it is 0, with `sdo_en`, `hold` and `sdo` all low.
- R11: A falling `sclk` edge that lands in the same synchronised cycle as the chip-select release is counted before the mode decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idle high, asynchronous |
| sample_word | input | DATA_W | Parallel sample latched at frame start |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | Output enable; low means high impedance |
| hold | output | 1 | Sampler in hold |
| hold_pulse | output | 1 | One-cycle pulse entering hold |
| track_pulse | output | 1 | One-cycle pulse returning to track |
| pwr_state | output | 2 | 00 shutdown, 01 waking, 10 normal |
| frame_done | output | 1 | One-cycle pulse on a complete word |
| frame_valid | output | 1 | Pulse with frame_done for a non-dummy word |

## Verification
The release of chip-select and the edge counter's increment can fall in the same system cycle. This happens when the host raises chip-select at the same instant as a falling serial-clock edge, and the release decision then depends on whether that edge is counted. The bench drives both pins in the same time step so that both synchronisers deliver the two edges together. It does this once after 9 earlier falls, where the combined edge must count as the 10th and keep normal mode, and once after 1 earlier fall, where it must count as the 2nd and enter shutdown. In each case the mode is judged at the `pwr_state` port after the frame has settled.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        PM_SHDN = 2'b00,
        PM_WAKE = 2'b01,
        PM_NORM = 2'b10
    } pmode_e;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{IDLE}};
            st_q.prev  <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.chain[STAGES-1] & st_q.prev;

endmodule

// File: rtl/sadc_frame.sv
module sadc_frame #(
    parameter int DATA_W     = 12,
    parameter int LEAD_Z     = 3,
    parameter int TRACK_RISE = 13,
    localparam int WORD_LEN  = LEAD_Z + DATA_W + 1,
    localparam int CNT_W     = $clog2(WORD_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic [DATA_W-1:0] sample_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              hold_pulse,
    output logic              track_pulse,
    output logic              rel_evt,
    output logic [CNT_W-1:0]  rel_cnt,
    output logic              fall_tick,
    output logic [CNT_W-1:0]  tick_cnt,
    output logic              done_evt
);

    typedef struct packed {
        logic                active;
        logic [CNT_W-1:0]    falls;
        logic [CNT_W-1:0]    rises;
        logic                hold;
        logic                en;
        logic [WORD_LEN-1:0] shreg;
        logic                hpulse;
        logic                tpulse;
    } frm_st_t;

    frm_st_t st_d, st_q;

    logic             fall_ok;
    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] rise_nxt;

    always_comb begin
        fall_ok  = st_q.active && sclk_fall && (st_q.falls != CNT_W'(WORD_LEN));
        eff_cnt  = st_q.falls + CNT_W'(fall_ok);
        rise_nxt = st_q.rises + CNT_W'(1);

        st_d        = st_q;
        st_d.hpulse = 1'b0;
        st_d.tpulse = 1'b0;

        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.falls  = '0;
            st_d.rises  = '0;
            st_d.hold   = 1'b1;
            st_d.en     = 1'b1;
            st_d.shreg  = {{LEAD_Z{1'b0}}, sample_word, 1'b0};
            st_d.hpulse = 1'b1;
        end else if (cs_rise) begin
            st_d.active = 1'b0;
            st_d.en     = 1'b0;
            if (st_q.hold) begin
                st_d.hold   = 1'b0;
                st_d.tpulse = 1'b1;
            end
        end else if (st_q.active) begin
            if (fall_ok) begin
                st_d.falls = eff_cnt;
                st_d.shreg = {st_q.shreg[WORD_LEN-2:0], 1'b0};
                if (eff_cnt == CNT_W'(WORD_LEN)) begin
                    st_d.en = 1'b0;
                end
            end
            if (sclk_rise && (st_q.rises != CNT_W'(WORD_LEN))) begin
                st_d.rises = rise_nxt;
                if ((rise_nxt == CNT_W'(TRACK_RISE)) && st_q.hold) begin
                    st_d.hold   = 1'b0;
                    st_d.tpulse = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo         = st_q.en & st_q.shreg[WORD_LEN-1];
    assign sdo_en      = st_q.en;
    assign hold        = st_q.hold;
    assign hold_pulse  = st_q.hpulse;
    assign track_pulse = st_q.tpulse;
    assign rel_evt     = cs_rise & st_q.active;
    assign rel_cnt     = eff_cnt;
    assign fall_tick   = fall_ok & ~cs_rise & ~cs_fall;
    assign tick_cnt    = eff_cnt;
    assign done_evt    = fall_ok & (eff_cnt == CNT_W'(WORD_LEN));

endmodule

// File: rtl/sadc_mode.sv
module sadc_mode
    import sadc_pkg::*;
#(
    parameter int   CNT_W        = 5,
    parameter int   SHDN_FROM    = 2,
    parameter int   NORMAL_FROM  = 10,
    parameter logic RESET_NORMAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             rel_evt,
    input  logic [CNT_W-1:0] rel_cnt,
    input  logic             fall_tick,
    input  logic [CNT_W-1:0] tick_cnt,
    input  logic             done_evt,
    output logic [1:0]       pwr_state,
    output logic             frame_done,
    output logic             frame_valid
);

    typedef struct packed {
        pmode_e mode;
        logic   pend;
        logic   dummy;
        logic   done;
        logic   valid;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.valid = 1'b0;

        if (cs_fall) begin
            st_d.dummy = st_q.pend | (st_q.mode != PM_NORM);
            st_d.pend  = 1'b0;
            if (st_q.mode == PM_SHDN) begin
                st_d.mode = PM_WAKE;
            end
        end

        if (rel_evt) begin
            unique case (st_q.mode)
                PM_NORM: begin
                    if ((rel_cnt >= CNT_W'(SHDN_FROM)) && (rel_cnt < CNT_W'(NORMAL_FROM))) begin
                        st_d.mode = PM_SHDN;
                    end
                end
                PM_WAKE: begin
                    st_d.mode = (rel_cnt >= CNT_W'(NORMAL_FROM)) ? PM_NORM : PM_SHDN;
                end
                default: st_d.mode = st_q.mode;
            endcase
        end else if (fall_tick && (st_q.mode == PM_WAKE) && (tick_cnt == CNT_W'(NORMAL_FROM))) begin
            st_d.mode = PM_NORM;
        end

        if (done_evt) begin
            st_d.done  = 1'b1;
            st_d.valid = ~st_q.dummy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= RESET_NORMAL ? PM_NORM : PM_SHDN;
            st_q.pend  <= 1'b1;
            st_q.dummy <= 1'b1;
            st_q.done  <= 1'b0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_state   = st_q.mode;
    assign frame_done  = st_q.done;
    assign frame_valid = st_q.valid;

endmodule

// File: rtl/sadc_pwr_ctrl.sv
module sadc_pwr_ctrl #(
    parameter int   DATA_W       = 12,
    parameter int   LEAD_Z       = 3,
    parameter int   SYNC_STAGES  = 2,
    parameter int   TRACK_RISE   = 13,
    parameter int   SHDN_FROM    = 2,
    parameter int   NORMAL_FROM  = 10,
    parameter logic RESET_NORMAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              hold,
    output logic              hold_pulse,
    output logic              track_pulse,
    output logic [1:0]        pwr_state,
    output logic              frame_done,
    output logic              frame_valid
);

    localparam int WORD_LEN = LEAD_Z + DATA_W + 1;
    localparam int CNT_W    = $clog2(WORD_LEN + 1);

    logic [1:0]       pin_rise;
    logic [1:0]       pin_fall;
    logic             cs_fall;
    logic             cs_rise;
    logic             sclk_fall;
    logic             sclk_rise;
    logic             rel_evt;
    logic [CNT_W-1:0] rel_cnt;
    logic             fall_tick;
    logic [CNT_W-1:0] tick_cnt;
    logic             done_evt;

    sadc_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES),
        .IDLE  (2'b11)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sclk, cs_n}),
        .rise    (pin_rise),
        .fall    (pin_fall)
    );

    assign cs_fall   = pin_fall[0];
    assign cs_rise   = pin_rise[0];
    assign sclk_fall = pin_fall[1];
    assign sclk_rise = pin_rise[1];

    sadc_frame #(
        .DATA_W    (DATA_W),
        .LEAD_Z    (LEAD_Z),
        .TRACK_RISE(TRACK_RISE)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_fall  (sclk_fall),
        .sclk_rise  (sclk_rise),
        .sample_word(sample_word),
        .sdo        (sdo),
        .sdo_en     (sdo_en),
        .hold       (hold),
        .hold_pulse (hold_pulse),
        .track_pulse(track_pulse),
        .rel_evt    (rel_evt),
        .rel_cnt    (rel_cnt),
        .fall_tick  (fall_tick),
        .tick_cnt   (tick_cnt),
        .done_evt   (done_evt)
    );

    sadc_mode #(
        .CNT_W       (CNT_W),
        .SHDN_FROM   (SHDN_FROM),
        .NORMAL_FROM (NORMAL_FROM),
        .RESET_NORMAL(RESET_NORMAL)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .rel_evt    (rel_evt),
        .rel_cnt    (rel_cnt),
        .fall_tick  (fall_tick),
        .tick_cnt   (tick_cnt),
        .done_evt   (done_evt),
        .pwr_state  (pwr_state),
        .frame_done (frame_done),
        .frame_valid(frame_valid)
    );

endmodule

// File: rtl/sadc_pwr_chk.sv
module sadc_pwr_chk #(
    parameter int CNT_W       = 5,
    parameter int SHDN_FROM   = 2,
    parameter int NORMAL_FROM = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_fall,
    input logic             hold,
    input logic             sdo_en,
    input logic             track_pulse,
    input logic             done_evt,
    input logic             rel_evt,
    input logic [CNT_W-1:0] rel_cnt,
    input logic [1:0]       pwr_state,
    input logic             frame_done,
    input logic             frame_valid
);

    AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (hold && sdo_en)); // R1

    AST_TRACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        track_pulse |-> !hold); // R3

    AST_WORD_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !sdo_en); // R4

    AST_NOISE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && pwr_state == 2'b10 && rel_cnt < CNT_W'(SHDN_FROM)) |=> pwr_state == 2'b10); // R5

    AST_WINDOW_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && pwr_state == 2'b10 && rel_cnt >= CNT_W'(SHDN_FROM)
         && rel_cnt < CNT_W'(NORMAL_FROM)) |=> pwr_state == 2'b00); // R6

    AST_LATE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && pwr_state == 2'b10 && rel_cnt >= CNT_W'(NORMAL_FROM)) |=> pwr_state == 2'b10); // R7

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11); // R8

    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> frame_done); // R9

endmodule

bind sadc_pwr_ctrl sadc_pwr_chk #(
    .CNT_W      (CNT_W),
    .SHDN_FROM  (SHDN_FROM),
    .NORMAL_FROM(NORMAL_FROM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall),
    .hold       (hold),
    .sdo_en     (sdo_en),
    .track_pulse(track_pulse),
    .done_evt   (done_evt),
    .rel_evt    (rel_evt),
    .rel_cnt    (rel_cnt),
    .pwr_state  (pwr_state),
    .frame_done (frame_done),
    .frame_valid(frame_valid)
);

// File: tb/sadc_pwr_ctrl_tb_top.sv
module sadc_pwr_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int GAP        = 10;
    localparam int NROWS      = 16;

    // {clocks[4:0], word[11:0], mid_state[1:0], end_state[1:0], done, valid}
    localparam logic [22:0] VEC [NROWS] = '{
        {5'd16, 12'hABC, 2'b10, 2'b10, 1'b1, 1'b0},
        {5'd16, 12'h5A3, 2'b10, 2'b10, 1'b1, 1'b1},
        {5'd1,  12'h0F0, 2'b10, 2'b10, 1'b0, 1'b0},
        {5'd16, 12'hFFF, 2'b10, 2'b10, 1'b1, 1'b1},
        {5'd12, 12'h3A5, 2'b10, 2'b10, 1'b0, 1'b0},
        {5'd5,  12'h111, 2'b10, 2'b00, 1'b0, 1'b0},
        {5'd4,  12'h222, 2'b01, 2'b00, 1'b0, 1'b0},
        {5'd16, 12'h001, 2'b01, 2'b10, 1'b1, 1'b0},
        {5'd16, 12'h800, 2'b10, 2'b10, 1'b1, 1'b1},
        {5'd2,  12'h333, 2'b10, 2'b00, 1'b0, 1'b0},
        {5'd10, 12'h444, 2'b01, 2'b10, 1'b0, 1'b0},
        {5'd16, 12'h123, 2'b10, 2'b10, 1'b1, 1'b1},
        {5'd9,  12'h555, 2'b10, 2'b00, 1'b0, 1'b0},
        {5'd16, 12'h7E5, 2'b01, 2'b10, 1'b1, 1'b0},
        {5'd10, 12'h666, 2'b10, 2'b10, 1'b0, 1'b0},
        {5'd20, 12'h3C6, 2'b10, 2'b10, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_word = '0;

    logic       sdo, sdo_en, hold, hold_pulse, track_pulse, frame_done, frame_valid;
    logic [1:0] pwr_state;
    logic       s_sdo, s_sdo_en, s_hold, s_hold_pulse, s_track_pulse, s_frame_done, s_frame_valid;
    logic [1:0] s_pwr_state;

    int total = 0;
    int bad   = 0;
    int n_hp = 0, n_tp = 0, n_done = 0, n_valid = 0, n_sdone = 0, n_svalid = 0;

    logic [15:0] cap_bits;
    logic [1:0]  cap_mid, cap_smid;
    logic        en_start, en16, h12, h13;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_pwr_ctrl #(.RESET_NORMAL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_word(sample_word),
        .sdo(sdo), .sdo_en(sdo_en), .hold(hold), .hold_pulse(hold_pulse),
        .track_pulse(track_pulse), .pwr_state(pwr_state),
        .frame_done(frame_done), .frame_valid(frame_valid)
    );

    sadc_pwr_ctrl #(.RESET_NORMAL(1'b0)) dut_sd_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_word(sample_word),
        .sdo(s_sdo), .sdo_en(s_sdo_en), .hold(s_hold), .hold_pulse(s_hold_pulse),
        .track_pulse(s_track_pulse), .pwr_state(s_pwr_state),
        .frame_done(s_frame_done), .frame_valid(s_frame_valid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            n_hp     += int'(hold_pulse);
            n_tp     += int'(track_pulse);
            n_done   += int'(frame_done);
            n_valid  += int'(frame_valid);
            n_sdone  += int'(s_frame_done);
            n_svalid += int'(s_frame_valid);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input int n, input logic [11:0] w);
        cap_bits = '0;
        cap_mid = 2'b11;
        cap_smid = 2'b11;
        en16 = 1'b1;
        h12 = 1'b0;
        h13 = 1'b1;
        sample_word = w;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        en_start = sdo_en;
        cap_bits[15] = sdo;
        for (int i = 1; i <= n; i++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            if (i <= 15) cap_bits[15-i] = sdo;
            if (i == 16) en16 = sdo_en;
            if (i == 1) begin
                cap_mid = pwr_state;
                cap_smid = s_pwr_state;
            end
            sclk = 1'b1;
            wait_clk(HALF);
            if (i == 12) h12 = hold;
            if (i == 13) h13 = hold;
        end
        cs_n = 1'b1;
        wait_clk(GAP);
    endtask

    task automatic run_coinc(input int pre);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < pre; i++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        cs_n = 1'b1;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(GAP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R10 reset state for both parameter choices
        chk(pwr_state == 2'b10, "R10 reset normal", pwr_state, 2'b10);
        chk(s_pwr_state == 2'b00, "R10 reset shutdown", s_pwr_state, 2'b00);
        chk(!sdo_en && !hold && !sdo, "R10 outputs idle", {sdo_en, hold, sdo}, 0);

        for (int r = 0; r < NROWS; r++) begin
            automatic int          n   = int'(VEC[r][22:18]);
            automatic logic [11:0] w   = VEC[r][17:6];
            automatic logic [1:0]  mid = VEC[r][5:4];
            automatic logic [1:0]  fin = VEC[r][3:2];
            automatic int          d   = int'(VEC[r][1]);
            automatic int          v   = int'(VEC[r][0]);
            automatic int hp0 = n_hp, tp0 = n_tp, dn0 = n_done, vl0 = n_valid;
            automatic int sd0 = n_sdone, sv0 = n_svalid;
            run_frame(n, w);
            chk(en_start, "R1 enable on start", en_start, 1);
            chk(n_hp - hp0 == 1, "R1 one hold pulse", n_hp - hp0, 1);
            chk(n_tp - tp0 == 1, "R3 one track pulse", n_tp - tp0, 1);
            chk(!sdo_en && !hold, "R4 idle after release", {sdo_en, hold}, 0);
            chk(cap_mid == mid, "R8 state during frame", cap_mid, mid);
            if (n >= 16) begin
                chk(cap_bits == {3'b000, w, 1'b0}, "R2 word bits", cap_bits, {3'b000, w, 1'b0});
                chk(!en16, "R4 enable off at 16th fall", en16, 0);
            end
            if (n >= 13) begin
                chk(h12 && !h13, "R3 track at 13th rise", {h12, h13}, 2'b10);
            end
            if (n < 2)
                chk(pwr_state == fin, "R5 noise release", pwr_state, fin);
            else if (n < 10)
                chk(pwr_state == fin, "R6 window release", pwr_state, fin);
            else if (n < 16)
                chk(pwr_state == fin, "R7 late release", pwr_state, fin);
            else
                chk(pwr_state == fin, "R8 state after word", pwr_state, fin);
            chk(n_done - dn0 == d, "R9 frame done", n_done - dn0, d);
            chk(n_valid - vl0 == v, "R9 frame valid", n_valid - vl0, v);
            if (r == 0) begin
                chk(cap_smid == 2'b01, "R8 waking from reset shutdown", cap_smid, 2'b01);
                chk(s_pwr_state == 2'b10, "R8 normal after 10th fall", s_pwr_state, 2'b10);
                chk(n_sdone - sd0 == 1 && n_svalid - sv0 == 0, "R9 start-up dummy",
                    n_svalid - sv0, 0);
            end
        end

        // R11: 9 falls then release together with the 10th fall: stays normal
        run_coinc(9);
        chk(pwr_state == 2'b10, "R11 coincident 10th fall", pwr_state, 2'b10);
        // R11: 1 fall then release together with the 2nd fall: shutdown
        run_coinc(1);
        chk(pwr_state == 2'b00, "R11 coincident 2nd fall", pwr_state, 2'b00);
        begin
            automatic int dn0 = n_done, vl0 = n_valid;
            run_frame(16, 12'hC3A);
            chk(n_done - dn0 == 1 && n_valid - vl0 == 0, "R9 dummy after shutdown",
                n_valid - vl0, 0);
            chk(cap_bits == {3'b000, 12'hC3A, 1'b0}, "R2 word after wake",
                cap_bits, {3'b000, 12'hC3A, 1'b0});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule